// File: doc/BRIEF.md
# Multi-Channel Compare Match Timer

This peripheral holds several independent timer channels behind one small register bus. Each channel owns an up-counter, a compare register and a control/status register. A single shared run register, common to all channels, carries one run bit per channel. While its run bit is set, a channel counts ticks of a per-channel divide-by-`PRESCALE` prescaler (eight by default). On the tick at which the count equals the compare value, the counter returns to zero. On that same edge a match flag is set. This gives a periodic timer whose period is (compare + 1) ticks.

Software acknowledges a match by writing zero to the flag bit of the control/status register. Writing one to a flag leaves it as it was. A second flag records a match that arrives while the first is still pending. Each channel drives an interrupt line, which is the match flag gated by an enable bit.

Two layouts are selected by `WIDE`:
- **Narrow layout (`WIDE` = 0):** 16-bit counters, register index scaled by 2, match flag at bit 7, pending-overrun flag at bit 6, interrupt enable at bit 5.
- **Wide layout (`WIDE` = 1):** 32-bit counters and compare registers, register index scaled by 4, match flag at bit 15, overrun flag at bit 14, interrupt enable at bit 6.

Top module: `match_timer`

## Requirements
- R1: After reset the run register reads 0, every counter reads 0, every compare register reads all ones, every control/status register reads 0 and all interrupt lines are low.
- R2: Bit n of the run register (byte address 0) starts channel n when written 1 and stops it when written 0. A stopped channel holds its count. Channels whose bit is not set do not count.
- R3: A running counter advances by one once per `PRESCALE` clocks. The first increment lands on the `PRESCALE`-th rising edge after the edge that wrote the run bit.
- R4: On a tick where the count equals the compare value, the counter becomes 0 and the match flag (bit 7 narrow, bit 15 wide) is set on that same edge.
- R5: The interrupt line of a channel is high exactly while its match flag and its enable bit (bit 5 narrow, bit 6 wide) are both set. It stays high until software clears the flag.
- R6: Writing 0 to a flag bit clears it and writing 1 leaves it unchanged. A match on the same edge as a clearing write leaves the flag set.
- R7: The overrun flag (bit 6 narrow, bit 14 wide) is set when a match occurs while the match flag was already set. It is cleared by writing 0 to it, and setting wins over clearing.
- R8: Channel n occupies byte addresses from 16*(n+1). Control/status, counter and compare sit at register index 0, 1 and 2. The index is multiplied by 2 (narrow) or 4 (wide) to form the offset. Misaligned or unmapped addresses read 0 and ignore writes.
- R9: A compare value written below the current count takes effect at once. The counter runs on to all ones, wraps to 0 and sets no flag on that wrap.
- R10: Counter and compare registers accept writes while the channel is stopped and read back the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read enable; read data is combinational |
| busWrData | input | CNT_W | Write data |
| busRdData | output | CNT_W | Read data; 0 when not reading or unmapped |
| irq | output | NUM_CH | Per-channel interrupt request |

## Verification
The bench first aims at the tick boundary. It reads the count one clock before and on the eighth edge after start, so an off-by-one prescaler shows up as an early or late increment. It then checks that the flag appears on exactly the edge that zeroes the counter. A design that compared against the incremented count, or set the flag one cycle late, would fail there. Further cases cover a clearing write that lands on a match edge, where a design that let the write win would lose an event. They also cover a second match with the flag still pending, which must raise the overrun flag, and writes of one to the flag bits, which must not clear them. Finally, a compare value below a preloaded count must wrap through all ones without a flag, and a stopped channel must hold its count.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;

  // Per-channel write strobes produced by the bus decoder.
  typedef struct packed {
    logic csrWr;
    logic cntWr;
    logic cmpWr;
  } chStrobe_t;

  function automatic int cntWidth(input bit wide);
    return wide ? 32 : 16;
  endfunction

  function automatic int flagPos(input bit wide);
    return wide ? 15 : 7;
  endfunction

  function automatic int ovrPos(input bit wide);
    return wide ? 14 : 6;
  endfunction

  function automatic int iePos(input bit wide);
    return wide ? 6 : 5;
  endfunction

endpackage

// File: rtl/mt_bus_ctrl.sv
module mt_bus_ctrl
  import match_timer_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter bit WIDE    = 1'b0,
  parameter int ADDR_W  = 8,
  parameter int CH_SPAN = 16,
  localparam int CNT_W  = cntWidth(WIDE)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic                            busWr,
  input  logic                            busRd,
  input  logic [CNT_W-1:0]                busWrData,
  input  logic [NUM_CH-1:0][15:0]         csrView,
  input  logic [NUM_CH-1:0][CNT_W-1:0]    cntView,
  input  logic [NUM_CH-1:0][CNT_W-1:0]    cmpView,
  output chStrobe_t [NUM_CH-1:0]          strobes,
  output logic [NUM_CH-1:0]               runBits,
  output logic [CNT_W-1:0]                busRdData
);

  localparam int SH = WIDE ? 2 : 1;
  localparam logic [ADDR_W-1:0] WIN = ADDR_W'(3 << SH);

  logic [NUM_CH-1:0] runReg;
  logic              startHit;

  assign startHit = (busAddr == '0);
  assign runBits  = runReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runReg <= '0;
    end else if (busWr && startHit) begin
      runReg <= busWrData[NUM_CH-1:0];
    end
  end

  always_comb begin
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] idx;
    logic [CNT_W-1:0]  rdVal;
    strobes = '0;
    rdVal   = '0;
    if (startHit) rdVal = CNT_W'(runReg);
    for (int c = 0; c < NUM_CH; c++) begin
      base = ADDR_W'(CH_SPAN * (c + 1));
      rel  = busAddr - base;
      idx  = rel >> SH;
      if (busAddr >= base && rel < WIN && rel[SH-1:0] == '0) begin
        case (idx)
          ADDR_W'(0): begin
            strobes[c].csrWr = busWr;
            rdVal = CNT_W'(csrView[c]);
          end
          ADDR_W'(1): begin
            strobes[c].cntWr = busWr;
            rdVal = cntView[c];
          end
          default: begin
            strobes[c].cmpWr = busWr;
            rdVal = cmpView[c];
          end
        endcase
      end
    end
    busRdData = busRd ? rdVal : '0;
  end

endmodule

// File: rtl/mt_channel_path.sv
module mt_channel_path
  import match_timer_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter bit WIDE     = 1'b0,
  parameter int PRESCALE = 8,
  localparam int CNT_W   = cntWidth(WIDE)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  chStrobe_t [NUM_CH-1:0]          strobes,
  input  logic [NUM_CH-1:0]               runBits,
  input  logic [CNT_W-1:0]                busWrData,
  output logic [NUM_CH-1:0][15:0]         csrView,
  output logic [NUM_CH-1:0][CNT_W-1:0]    cntView,
  output logic [NUM_CH-1:0][CNT_W-1:0]    cmpView,
  output logic [NUM_CH-1:0]               irq
);

  localparam int PSC_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int F_POS  = flagPos(WIDE);
  localparam int O_POS  = ovrPos(WIDE);
  localparam int IE_POS = iePos(WIDE);
  localparam logic [PSC_W-1:0] PSC_LAST = PSC_W'(PRESCALE - 1);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [PSC_W-1:0] pscCnt;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] compare;
    logic             matchFlag;
    logic             ovrFlag;
    logic             irqEn;
    logic             tick;
    logic             hit;

    assign tick = runBits[c] && (pscCnt == PSC_LAST);
    assign hit  = tick && (count == compare);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pscCnt <= '0;
      end else if (!runBits[c] || tick) begin
        pscCnt <= '0;
      end else begin
        pscCnt <= pscCnt + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        count <= '0;
      end else if (strobes[c].cntWr) begin
        count <= busWrData;
      end else if (hit) begin
        count <= '0;
      end else if (tick) begin
        count <= count + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        compare <= '1;
      end else if (strobes[c].cmpWr) begin
        compare <= busWrData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        matchFlag <= 1'b0;
        ovrFlag   <= 1'b0;
        irqEn     <= 1'b0;
      end else begin
        if (strobes[c].csrWr) begin
          irqEn <= busWrData[IE_POS];
          if (!busWrData[F_POS]) matchFlag <= 1'b0;
          if (!busWrData[O_POS]) ovrFlag   <= 1'b0;
        end
        if (hit) begin
          matchFlag <= 1'b1;
          if (matchFlag) ovrFlag <= 1'b1;
        end
      end
    end

    always_comb begin
      csrView[c]         = '0;
      csrView[c][F_POS]  = matchFlag;
      csrView[c][O_POS]  = ovrFlag;
      csrView[c][IE_POS] = irqEn;
    end

    assign cntView[c] = count;
    assign cmpView[c] = compare;
    assign irq[c]     = matchFlag & irqEn;
  end

endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter bit WIDE     = 1'b0,
  parameter int PRESCALE = 8,
  parameter int ADDR_W   = 8,
  parameter int CH_SPAN  = 16,
  localparam int CNT_W   = cntWidth(WIDE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [CNT_W-1:0]  busRdData,
  output logic [NUM_CH-1:0] irq
);

  chStrobe_t [NUM_CH-1:0]         strobes;
  logic [NUM_CH-1:0]              runBits;
  logic [NUM_CH-1:0][15:0]        csrView;
  logic [NUM_CH-1:0][CNT_W-1:0]   cntView;
  logic [NUM_CH-1:0][CNT_W-1:0]   cmpView;

  mt_bus_ctrl #(
    .NUM_CH(NUM_CH), .WIDE(WIDE), .ADDR_W(ADDR_W), .CH_SPAN(CH_SPAN)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .csrView(csrView), .cntView(cntView),
    .cmpView(cmpView), .strobes(strobes), .runBits(runBits),
    .busRdData(busRdData)
  );

  mt_channel_path #(
    .NUM_CH(NUM_CH), .WIDE(WIDE), .PRESCALE(PRESCALE)
  ) path_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .runBits(runBits),
    .busWrData(busWrData), .csrView(csrView), .cntView(cntView),
    .cmpView(cmpView), .irq(irq)
  );

endmodule

// File: rtl/mt_checker.sv
module mt_checker
  import match_timer_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter bit WIDE    = 1'b0,
  localparam int CNT_W  = cntWidth(WIDE)
) (
  input logic                          clk,
  input logic                          rstN,
  input chStrobe_t [NUM_CH-1:0]        strobes,
  input logic [NUM_CH-1:0]             runBits,
  input logic [NUM_CH-1:0][15:0]       csrView,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cntView,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cmpView,
  input logic [NUM_CH-1:0]             irq
);

  localparam int F_POS = flagPos(WIDE);
  localparam logic [CNT_W-1:0] ALL1 = '1;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R2: a stopped channel keeps its count unless software writes it
    a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rstN)
      (!runBits[c] && !strobes[c].cntWr) |=> $stable(cntView[c]));

    // R3: a running counter only stays, steps by one, or returns to zero
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rstN)
      (runBits[c] && !strobes[c].cntWr) |=>
        (cntView[c] == $past(cntView[c]) ||
         cntView[c] == $past(cntView[c]) + 1'b1 ||
         cntView[c] == '0));

    // R4: leaving a nonzero matching count for zero comes with the flag
    a_r4_match_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
      (runBits[c] && !strobes[c].cntWr && cntView[c] == cmpView[c] &&
       cntView[c] != '0) |=> (cntView[c] != '0 || csrView[c][F_POS]));

    // R5: the interrupt holds until a control/status write
    a_r5_irq_holds: assert property (@(posedge clk) disable iff (!rstN)
      (irq[c] && !strobes[c].csrWr) |=> irq[c]);

    // R9: a wrap through all ones never raises the flag
    a_r9_wrap_no_flag: assert property (@(posedge clk) disable iff (!rstN)
      (cntView[c] == ALL1 && cmpView[c] != ALL1 && !strobes[c].cmpWr &&
       !csrView[c][F_POS]) |=> !csrView[c][F_POS]);
  end

endmodule

bind match_timer mt_checker #(.NUM_CH(NUM_CH), .WIDE(WIDE)) chk_i (
  .clk(clk), .rstN(rstN), .strobes(strobes), .runBits(runBits),
  .csrView(csrView), .cntView(cntView), .cmpView(cmpView), .irq(irq)
);

// File: tb/match_timer_tb_top.sv
module match_timer_tb_top;

  localparam int  NUM_CH = 2;
  localparam bit  WIDE   = 1'b0;
  localparam int  ADDR_W = 8;
  localparam int  CNT_W  = WIDE ? 32 : 16;
  localparam int  SCALE  = WIDE ? 4 : 2;
  localparam int  FB     = WIDE ? 15 : 7;
  localparam int  OB     = WIDE ? 14 : 6;
  localparam int  IB     = WIDE ? 6 : 5;
  localparam logic [31:0] MAXV = 32'((64'd1 << CNT_W) - 1);
  localparam logic [31:0] F  = 32'd1 << FB;
  localparam logic [31:0] O  = 32'd1 << OB;
  localparam logic [31:0] IE = 32'd1 << IB;

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWr = 1'b0;
  logic              busRd = 1'b0;
  logic [CNT_W-1:0]  busWrData = '0;
  logic [CNT_W-1:0]  busRdData;
  logic [NUM_CH-1:0] irq;
  logic              probeOn = 1'b0;

  item_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  match_timer #(.NUM_CH(NUM_CH), .WIDE(WIDE), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .busRdData(busRdData), .irq(irq)
  );

  function automatic logic [ADDR_W-1:0] regA(input int ch, input int idx);
    return ADDR_W'(16 * (ch + 1) + idx * SCALE);
  endfunction

  // Driver: every task spends exactly one clock edge
  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    busAddr = a; busWrData = CNT_W'(d); busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic readExp(input logic [ADDR_W-1:0] a, input logic [31:0] e,
                         input string tag);
    item_t it;
    it.isIrq = 1'b0; it.exp = e; it.tag = tag;
    expQ.push_back(it);
    busAddr = a; busRd = 1'b1; probeOn = 1'b1;
    @(negedge clk);
    busRd = 1'b0; probeOn = 1'b0;
  endtask

  task automatic irqExp(input logic [31:0] e, input string tag);
    item_t it;
    it.isIrq = 1'b1; it.exp = e; it.tag = tag;
    expQ.push_back(it);
    probeOn = 1'b1;
    @(negedge clk);
    probeOn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: samples mid high phase after the edge of each probe
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (probeOn && expQ.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = expQ.pop_front();
        act = it.isIrq ? 32'(irq) : 32'(busRdData);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    readExp(8'd0, 32'd0, "R1 run register");
    readExp(regA(0, 0), 32'd0, "R1 ch0 csr");
    readExp(regA(1, 0), 32'd0, "R1 ch1 csr");
    readExp(regA(0, 1), 32'd0, "R1 ch0 count");
    readExp(regA(0, 2), MAXV, "R1 ch0 compare");
    readExp(regA(1, 2), MAXV, "R1 ch1 compare");
    irqExp(32'd0, "R1 irq low");

    // R10 loads while stopped; R8 layout and unmapped holes
    busWrite(regA(0, 1), 32'h0123);
    readExp(regA(0, 1), 32'h0123, "R10 count load");
    busWrite(regA(1, 2), 32'h00A5);
    readExp(regA(1, 2), 32'h00A5, "R8 ch1 compare stride");
    readExp(regA(0, 2), MAXV, "R8 ch1 write left ch0");
    readExp(ADDR_W'(16 + 1), 32'd0, "R8 misaligned reads zero");
    readExp(regA(0, 3), 32'd0, "R8 index 3 reads zero");
    busWrite(regA(0, 1), 32'd0);
    busWrite(regA(0, 2), 32'd3);
    readExp(regA(0, 2), 32'd3, "R10 compare load");
    busWrite(regA(0, 0), MAXV);
    readExp(regA(0, 0), IE, "R6 writing ones sets no flag");

    // Start ch0 only (edge m=0)
    busWrite(8'd0, 32'd1);
    idle(6);
    readExp(regA(0, 1), 32'd0, "R3 no step before prescale");       // m=7
    readExp(regA(0, 1), 32'd1, "R3 first step on eighth edge");     // m=8
    readExp(regA(1, 1), 32'd0, "R2 stopped ch1 does not count");    // m=9
    idle(21);
    readExp(regA(0, 0), IE, "R4 no flag before match");             // m=31
    readExp(regA(0, 0), F | IE, "R4 flag on match edge");           // m=32
    irqExp(32'd1, "R5 irq raised");                                 // m=33
    readExp(regA(0, 1), 32'd0, "R4 counter cleared");               // m=34
    busWrite(regA(0, 0), IE);                                       // m=35
    readExp(regA(0, 0), IE, "R6 write zero clears flag");           // m=36
    irqExp(32'd0, "R5 irq drops after clear");                      // m=37
    idle(26);
    readExp(regA(0, 0), F | IE, "R4 periodic second match");        // m=64
    busWrite(regA(0, 0), MAXV);                                     // m=65
    readExp(regA(0, 0), F | IE, "R6 writing one keeps flag");       // m=66
    idle(29);
    readExp(regA(0, 0), F | O | IE, "R7 overrun on pending match"); // m=96
    busWrite(regA(0, 0), IE);                                       // m=97
    readExp(regA(0, 0), IE, "R7 overrun cleared by zero");          // m=98
    busWrite(regA(0, 0), 32'd0);                                    // m=99
    idle(28);
    readExp(regA(0, 0), F, "R4 flag without enable");               // m=128
    irqExp(32'd0, "R5 no irq while disabled");                      // m=129
    busWrite(regA(0, 0), IE | F | O);                               // m=130
    irqExp(32'd1, "R5 irq on enable with flag set");                // m=131
    readExp(regA(0, 0), F | IE, "R7 no overrun from single match"); // m=132
    idle(27);
    busWrite(regA(0, 0), IE);                                       // m=160 clash
    readExp(regA(0, 0), F | O | IE, "R6 match wins over clear");    // m=161
    busWrite(8'd0, 32'd0);                                          // m=162
    readExp(regA(0, 1), 32'd0, "R2 stop after match");              // m=163

    // R9 compare below count: wrap through all ones
    busWrite(regA(0, 1), MAXV - 32'd15);
    busWrite(regA(0, 2), 32'd5);
    busWrite(regA(0, 0), IE);
    busWrite(8'd1, 32'd0);  // unmapped byte: ignored
    readExp(8'd0, 32'd0, "R8 unmapped write ignored");
    busWrite(8'd0, 32'd1);                                          // m'=0
    idle(126);
    readExp(regA(0, 1), MAXV, "R9 count reaches all ones");         // m'=127
    readExp(regA(0, 1), 32'd0, "R9 count wraps to zero");          // m'=128
    readExp(regA(0, 0), IE, "R9 wrap sets no flag");                // m'=129
    idle(7);
    readExp(regA(0, 1), 32'd1, "R3 counting resumes after wrap");   // m'=137
    busWrite(8'd0, 32'd0);                                          // m'=138
    readExp(regA(0, 1), 32'd1, "R2 stopped count read");            // m'=139
    idle(30);
    readExp(regA(0, 1), 32'd1, "R2 stopped count held");            // m'=170

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule